// File: doc/BRIEF.md
# Byte Mailbox with Shared Status Register

This block is a two-way, one-byte mailbox between a host-side register port and a local-controller register port. A byte the host writes lands in an inbound register for the local side. A byte the local side writes lands in an outbound register for the host. An eight-bit status register is readable from both ports. Each port addresses two locations through a one-bit select: a data location and a control location.

Three status bits are owned by hardware. Bit 1 shows that the inbound byte has not been consumed. Bit 0 shows that the outbound byte has not been consumed. Bit 3 records whether the host's latest write went to the control location (a command) or to the data location. The remaining bits (7, 6, 5, 4, 2) belong to local software, which uses them to publish protocol state that the host can only read.

Each side gets a level interrupt while a byte is waiting for it. A status-register update raises no interrupt, so local software that needs to alert the host must follow the update with a byte in the outbound register. Writing over an unconsumed byte replaces it and latches a sticky overrun indicator for debug.

Top module: `mbx_byte_mailbox`

## Requirements
- R1: A host write with select 0 (data) stores the byte in the inbound register, sets status bit 1 and clears status bit 3.
- R2: A host write with select 1 (command) stores the byte in the inbound register, sets status bit 1 and sets status bit 3. Bit 3 holds its value until the next host write.
- R3: With select 0, the local read port returns the inbound byte. A local read strobe with select 0 clears status bit 1 on the following cycle, unless a host write arrives in the same cycle.
- R4: A local write with select 0 stores the byte in the outbound register and sets status bit 0. With select 0, the host read port returns the outbound byte, and a host read strobe clears bit 0, unless a local data write arrives in the same cycle.
- R5: `loc_irq` is high exactly while status bit 1 is set, and `host_irq` is high exactly while status bit 0 is set.
- R6: A local write with select 1 replaces status bits 7, 6, 5, 4 and 2 with the written byte's values in those positions and leaves bits 3, 1 and 0 unchanged. No other action changes bits 7, 6, 5, 4 and 2.
- R7: A local status write raises neither interrupt.
- R8: A write to a data register whose full flag is already set, with no acknowledging read in the same cycle, replaces the byte and keeps the flag set. It also sets the sticky overrun output for that direction (`in_overrun` or `out_overrun`), which stays set until reset.
- R9: A write and an acknowledging read of the same data register in one cycle return the old byte to the reader, store the new byte, leave the full flag set and do not flag an overrun.
- R10: Reset clears both data registers, all status bits, both interrupts and both overrun outputs.
- R11: Reading the status location from either port (select 1) changes no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_sel | input | 1 | Host location: 0 data, 1 command/status |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Outbound byte (select 0) or status (select 1) |
| loc_wr | input | 1 | Local write strobe |
| loc_rd | input | 1 | Local read strobe |
| loc_sel | input | 1 | Local location: 0 data, 1 status |
| loc_wdata | input | 8 | Local write byte |
| loc_rdata | output | 8 | Inbound byte (select 0) or status (select 1) |
| host_irq | output | 1 | Level interrupt to the host: outbound byte waiting |
| loc_irq | output | 1 | Level interrupt to the local side: inbound byte waiting |
| in_overrun | output | 1 | Sticky: inbound byte overwritten unread |
| out_overrun | output | 1 | Sticky: outbound byte overwritten unread |

## Verification
The bound checker runs on every cycle. It checks that each write sets its full flag and that an uncontested acknowledging read clears it. It also checks that bit 3 follows the host's last select, that the software bits move only on a local status write, that each interrupt tracks its flag, and that both overrun bits stay set once latched. The checker cannot tell which byte a reader actually receives, so the bench's directed scenarios cover the data path. These scenarios include the old-byte return when a write collides with a read, the byte that survives an overwrite, the exact status value after software writes stray bits into hardware positions, and the full clear on reset.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int STAT_W  = 8;
  localparam int OBF_BIT = 0;
  localparam int IBF_BIT = 1;
  localparam int CD_BIT  = 3;
  localparam logic [STAT_W-1:0] SW_MASK = 8'hF4;

  typedef enum logic {SEL_DATA = 1'b0, SEL_CTRL = 1'b1} sel_e;

  // keep only the positions that local software owns
  function automatic logic [STAT_W-1:0] sw_only(input logic [STAT_W-1:0] v);
    return v & SW_MASK;
  endfunction

  // assemble the visible status byte from software bits and hardware flags
  function automatic logic [STAT_W-1:0] compose_status(
      input logic [STAT_W-1:0] sw, input logic cd, input logic ibf, input logic obf);
    logic [STAT_W-1:0] r;
    r          = sw_only(sw);
    r[CD_BIT]  = cd;
    r[IBF_BIT] = ibf;
    r[OBF_BIT] = obf;
    return r;
  endfunction
endpackage

// File: rtl/mbx_chan.sv
// One direction of the mailbox: a byte register, its full flag and a sticky overrun bit.
module mbx_chan #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rd_en,
  output logic [DATA_W-1:0] data_q,
  output logic              full_q,
  output logic              overrun_q,
  output logic              set_evt,
  output logic              clr_evt,
  output logic              ovr_evt
);
  // a write always wins over a simultaneous acknowledge
  assign set_evt = wr_en;
  assign clr_evt = rd_en && !wr_en;
  assign ovr_evt = wr_en && full_q && !rd_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_q    <= '0;
      full_q    <= 1'b0;
      overrun_q <= 1'b0;
    end else begin
      if (set_evt) data_q <= wdata;
      if (set_evt)      full_q <= 1'b1;
      else if (clr_evt) full_q <= 1'b0;
      if (ovr_evt) overrun_q <= 1'b1;
    end
  end
endmodule

// File: rtl/mbx_status.sv
// Software-owned status bits plus the command/data flag.
module mbx_status
  import mbx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic              host_sel,
  input  logic              sw_wr,
  input  logic [STAT_W-1:0] sw_wdata,
  input  logic              ibf,
  input  logic              obf,
  output logic [STAT_W-1:0] status,
  output logic              cd_evt
);
  logic [STAT_W-1:0] sw_q;
  logic              cd_q;

  assign cd_evt = host_wr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sw_q <= '0;
      cd_q <= 1'b0;
    end else begin
      if (sw_wr)  sw_q <= sw_only(sw_wdata);
      if (cd_evt) cd_q <= (host_sel == SEL_CTRL);
    end
  end

  assign status = compose_status(sw_q, cd_q, ibf, obf);
endmodule

// File: rtl/mbx_byte_mailbox.sv
module mbx_byte_mailbox
  import mbx_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        host_wr,
  input  logic        host_rd,
  input  logic        host_sel,
  input  logic [7:0]  host_wdata,
  output logic [7:0]  host_rdata,
  input  logic        loc_wr,
  input  logic        loc_rd,
  input  logic        loc_sel,
  input  logic [7:0]  loc_wdata,
  output logic [7:0]  loc_rdata,
  output logic        host_irq,
  output logic        loc_irq,
  output logic        in_overrun,
  output logic        out_overrun
);
  localparam int DW = STAT_W;

  logic [DW-1:0] in_data, out_data, status_w;
  logic          ibf, obf;
  logic          in_set_evt, in_clr_evt, in_ovr_evt;
  logic          out_set_evt, out_clr_evt, out_ovr_evt;
  logic          cd_evt;
  logic          loc_data_rd, loc_data_wr, loc_stat_wr, host_data_rd;

  assign loc_data_rd  = loc_rd && (loc_sel == SEL_DATA);
  assign loc_data_wr  = loc_wr && (loc_sel == SEL_DATA);
  assign loc_stat_wr  = loc_wr && (loc_sel == SEL_CTRL);
  assign host_data_rd = host_rd && (host_sel == SEL_DATA);

  // host -> local
  mbx_chan #(.DATA_W(DW)) u_in (
    .clk(clk), .rst_n(rst_n), .wr_en(host_wr), .wdata(host_wdata), .rd_en(loc_data_rd),
    .data_q(in_data), .full_q(ibf), .overrun_q(in_overrun),
    .set_evt(in_set_evt), .clr_evt(in_clr_evt), .ovr_evt(in_ovr_evt)
  );

  // local -> host
  mbx_chan #(.DATA_W(DW)) u_out (
    .clk(clk), .rst_n(rst_n), .wr_en(loc_data_wr), .wdata(loc_wdata), .rd_en(host_data_rd),
    .data_q(out_data), .full_q(obf), .overrun_q(out_overrun),
    .set_evt(out_set_evt), .clr_evt(out_clr_evt), .ovr_evt(out_ovr_evt)
  );

  mbx_status u_stat (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_sel(host_sel),
    .sw_wr(loc_stat_wr), .sw_wdata(loc_wdata), .ibf(ibf), .obf(obf),
    .status(status_w), .cd_evt(cd_evt)
  );

  assign host_rdata = (host_sel == SEL_CTRL) ? status_w : out_data;
  assign loc_rdata  = (loc_sel == SEL_CTRL) ? status_w : in_data;
  assign loc_irq    = ibf;
  assign host_irq   = obf;
endmodule

// File: rtl/mbx_byte_mailbox_chk.sv
module mbx_byte_mailbox_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       host_wr,
  input logic       host_rd,
  input logic       host_sel,
  input logic       loc_wr,
  input logic       loc_rd,
  input logic       loc_sel,
  input logic [7:0] stat,
  input logic       host_irq,
  input logic       loc_irq,
  input logic       in_overrun,
  input logic       out_overrun
);
  // R1
  ibf_set_chk: assert property (@(posedge clk) disable iff (!rst_n) host_wr |=> stat[1]);
  // R2
  cd_track_chk: assert property (@(posedge clk) disable iff (!rst_n) host_wr |=> stat[3] == $past(host_sel));
  // R3
  ibf_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (loc_rd && !loc_sel && !host_wr) |=> !stat[1]);
  // R4
  obf_set_chk: assert property (@(posedge clk) disable iff (!rst_n) (loc_wr && !loc_sel) |=> stat[0]);
  // R4
  obf_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && !host_sel && !(loc_wr && !loc_sel)) |=> !stat[0]);
  // R5
  irq_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (loc_irq == stat[1]) && (host_irq == stat[0]));
  // R6
  sw_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(loc_wr && loc_sel) |=> ((stat & 8'hF4) == ($past(stat) & 8'hF4)));
  // R7
  stat_wr_no_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (loc_wr && loc_sel && !host_irq && !host_wr && !loc_irq) |=> (!host_irq && !loc_irq));
  // R8
  ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_overrun |=> in_overrun) and (out_overrun |=> out_overrun));
endmodule

bind mbx_byte_mailbox mbx_byte_mailbox_chk u_chk (
  .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd), .host_sel(host_sel),
  .loc_wr(loc_wr), .loc_rd(loc_rd), .loc_sel(loc_sel), .stat(status_w),
  .host_irq(host_irq), .loc_irq(loc_irq), .in_overrun(in_overrun), .out_overrun(out_overrun)
);

// File: tb/mbx_byte_mailbox_bench.sv
`timescale 1ns/1ps
module mbx_byte_mailbox_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic host_wr = 0, host_rd = 0, host_sel = 0, loc_wr = 0, loc_rd = 0, loc_sel = 0;
  logic [7:0] host_wdata = 0, loc_wdata = 0;
  logic [7:0] host_rdata, loc_rdata;
  logic host_irq, loc_irq, in_overrun, out_overrun;
  int errors = 0, checks = 0;
  bit done = 0;

  always #10 clk = ~clk;

  mbx_byte_mailbox u_mbx_byte_mailbox (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd), .host_sel(host_sel),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .loc_wr(loc_wr), .loc_rd(loc_rd),
    .loc_sel(loc_sel), .loc_wdata(loc_wdata), .loc_rdata(loc_rdata), .host_irq(host_irq),
    .loc_irq(loc_irq), .in_overrun(in_overrun), .out_overrun(out_overrun)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // advance one edge, then drop all strobes
  task automatic tick();
    @(posedge clk); #1;
    host_wr = 0; host_rd = 0; loc_wr = 0; loc_rd = 0;
  endtask

  task automatic hwrite(input logic sel, input logic [7:0] d);
    host_wr = 1; host_sel = sel; host_wdata = d; tick();
  endtask
  task automatic lwrite(input logic sel, input logic [7:0] d);
    loc_wr = 1; loc_sel = sel; loc_wdata = d; tick();
  endtask
  task automatic lread(output logic [7:0] d);
    loc_rd = 1; loc_sel = 0; #1 d = loc_rdata; tick();
  endtask
  task automatic hread(input logic sel, output logic [7:0] d);
    host_rd = 1; host_sel = sel; #1 d = host_rdata; tick();
  endtask
  function automatic logic [7:0] lstat();
    loc_sel = 1; return 8'h00;
  endfunction
  task automatic get_stat(output logic [7:0] s);
    host_sel = 1; #1 s = host_rdata;
  endtask

  task automatic t_reset();
    logic [7:0] s;
    get_stat(s);
    chk("R10 status", s, 8'h00);
    chk("R10 irqs", {host_irq, loc_irq}, 0);
    chk("R10 overruns", {in_overrun, out_overrun}, 0);
    loc_sel = 0; #1 chk("R10 inbound", loc_rdata, 0);
    host_sel = 0; #1 chk("R10 outbound", host_rdata, 0);
  endtask

  task automatic t_host_data();
    logic [7:0] s, d;
    hwrite(0, 8'hA5);
    get_stat(s);
    chk("R1 ibf", s[1], 1); chk("R1 cd", s[3], 0); chk("R5 loc_irq set", loc_irq, 1);
    lread(d);
    chk("R3 data", d, 8'hA5);
    get_stat(s);
    chk("R3 ibf cleared", s[1], 0); chk("R5 loc_irq clear", loc_irq, 0);
  endtask

  task automatic t_host_cmd();
    logic [7:0] s, d;
    hwrite(1, 8'h01);
    get_stat(s);
    chk("R2 ibf", s[1], 1); chk("R2 cd", s[3], 1);
    lread(d);
    chk("R2 cmd byte", d, 8'h01);
    get_stat(s);
    chk("R2 cd held", s[3], 1); chk("R3 ibf cleared", s[1], 0);
  endtask

  task automatic t_local_out();
    logic [7:0] s, d;
    lwrite(0, 8'h3C);
    chk("R5 host_irq set", host_irq, 1);
    hread(1, s); hread(1, s);
    chk("R11 host status read keeps flags", s, 8'h09);
    loc_rd = 1; loc_sel = 1; tick();
    get_stat(s);
    chk("R11 local status read keeps obf", s[0], 1);
    hread(0, d);
    chk("R4 data", d, 8'h3C);
    get_stat(s);
    chk("R4 obf cleared", s[0], 0); chk("R5 host_irq clear", host_irq, 0);
  endtask

  task automatic t_status();
    logic [7:0] s, d;
    lwrite(1, 8'hFF);
    get_stat(s);
    chk("R6 sw bits only", s, 8'hFC);
    chk("R7 no irq", {host_irq, loc_irq}, 0);
    hwrite(1, 8'hFF);
    get_stat(s);
    chk("R6 host cmd leaves sw bits", s, 8'hFE);
    lread(d);
    lwrite(1, 8'h0B);
    get_stat(s);
    chk("R6 sw cleared, hw kept", s, 8'h08);
  endtask

  task automatic t_collide();
    logic [7:0] s, d;
    hwrite(0, 8'h55);
    host_wr = 1; host_sel = 0; host_wdata = 8'h66; loc_rd = 1; loc_sel = 0;
    #1 d = loc_rdata; tick();
    chk("R9 old byte returned", d, 8'h55);
    get_stat(s);
    chk("R9 ibf kept", s[1], 1);
    chk("R9 no in overrun", in_overrun, 0);
    lread(d);
    chk("R9 new byte stored", d, 8'h66);
    lwrite(0, 8'h77);
    loc_wr = 1; loc_sel = 0; loc_wdata = 8'h88; host_rd = 1; host_sel = 0;
    #1 d = host_rdata; tick();
    chk("R9 out old byte", d, 8'h77);
    chk("R9 out flag kept", host_irq, 1);
    chk("R9 no out overrun", out_overrun, 0);
    hread(0, d);
    chk("R9 out new byte", d, 8'h88);
  endtask

  task automatic t_overrun();
    logic [7:0] s, d;
    hwrite(0, 8'h11); hwrite(0, 8'h22);
    get_stat(s);
    chk("R8 in overrun", in_overrun, 1); chk("R8 ibf kept", s[1], 1);
    lread(d);
    chk("R8 newest byte", d, 8'h22);
    chk("R8 overrun sticky", in_overrun, 1);
    lwrite(0, 8'h33); lwrite(0, 8'h44);
    chk("R8 out overrun", out_overrun, 1);
    hread(0, d);
    chk("R8 out newest", d, 8'h44);
  endtask

  task automatic t_reset_again();
    logic [7:0] s;
    hwrite(1, 8'h9A); lwrite(0, 8'hBC); lwrite(1, 8'hF0);
    rst_n = 0; tick(); rst_n = 1;
    get_stat(s);
    chk("R10 status after reset", s, 8'h00);
    chk("R10 irqs after reset", {host_irq, loc_irq}, 0);
    chk("R10 overruns after reset", {in_overrun, out_overrun}, 0);
    loc_sel = 0; #1 chk("R10 inbound after reset", loc_rdata, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    t_reset();
    t_host_data();
    t_host_cmd();
    t_local_out();
    t_status();
    t_collide();
    t_overrun();
    t_reset_again();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule